// File: doc/BRIEF.md
# MIDI Receive Byte Parser

This block sits behind a UART receiver and turns the stream of received MIDI bytes into complete events for a downstream ring buffer. Each received byte comes with three error flags; a byte carrying any of them is thrown away and counted. Clean bytes are sorted into real-time bytes, status bytes and data bytes. Real-time bytes leave at once on their own strobe and leave the parser state untouched. Status bytes become the running status, and data bytes are gathered under it until a channel message is complete. The complete message is then written to the ring buffer in one write of up to three bytes.

System Exclusive traffic passes through a manufacturer filter. The byte after the start byte is compared with a parameterised whitelist. A match starts a capture, which forwards the start byte, the ID and every later data byte, and ends with the end byte. A message that does not match is dropped silently. Before each write the parser compares the free space that the buffer reports with the space the write needs. A write that does not fit sets a sticky overflow flag and advances an overflow counter. The one exception is a Note On with velocity zero, which is dropped without any error being recorded.

Top module: `midi_rx_parser`

## Requirements
- R1: A byte received with any of the framing, parity or overrun flags set produces no event and no real-time strobe and changes no parser state, and the 8-bit serial error counter `serr_cnt` advances by one (wrapping) in the cycle after it.
- R2: A clean byte of 0xF8 or above pulses `rt_valid` for one cycle with the byte on `rt_byte`, one cycle after it is received. It writes no event and does not change the running status, a partly gathered message or the SysEx state.
- R3: A clean byte from 0x80 to 0xF7 becomes the running status and discards any partly gathered data. Later data bytes (bit 7 clear) are interpreted under it, so repeated messages may omit the status byte.
- R4: After reset the running status is none, and data bytes are discarded until a status byte arrives. Data bytes under running status 0xF1 to 0xF7, or under 0xF0 outside a SysEx capture, are discarded too.
- R5: The class is bits 6:4 of the running status. Classes 4 and 5 (status 0xC0 to 0xDF) complete after one data byte, and the other channel classes complete after two.
- R6: A completed channel message is written only when `buf_free` is at least 3. The write is one `ev_wr` pulse, one cycle after the last byte, with the status in `ev_data[7:0]`, the first data byte in `[15:8]`, the second in `[23:16]` (zero if absent), and `ev_len` equal to the byte count.
- R7: A write that does not fit (a channel message with `buf_free` below 3, or a SysEx write with `buf_free` below its `ev_len`) is dropped. It sets the sticky `ovf_flag` and advances the 8-bit `ovf_cnt` by one.
- R8: A Note On (class 1) whose velocity byte is 0 and which meets a buffer with fewer than 3 free entries is dropped, and neither `ovf_flag` nor `ovf_cnt` changes.
- R9: After 0xF0, the next data byte is compared with the whitelist (default 0x50, 0x41, 0x7E). On a match one write of `ev_len`=2 carries 0xF0 in `[7:0]` and the ID in `[15:8]`, and each later data byte is written alone with `ev_len`=1. On no match, nothing is written until the next status byte.
- R10: 0xF7 ends a capture. If a capture was active it is written alone with `ev_len`=1. Any other status byte also ends the SysEx state without writing anything.
- R11: Synchronous active-high reset clears `ev_wr`, `rt_valid`, both counters and `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_err_frame | input | 1 | Framing error on this byte |
| rx_err_parity | input | 1 | Parity error on this byte |
| rx_err_overrun | input | 1 | Overrun error on this byte |
| buf_free | input | FREE_W | Free entries reported by the event ring buffer |
| ev_wr | output | 1 | Event write strobe |
| ev_len | output | 2 | Number of valid bytes in the write (1 to 3) |
| ev_data | output | 24 | Event bytes, first byte in the low lane |
| rt_valid | output | 1 | Real-time byte strobe |
| rt_byte | output | 8 | Real-time byte |
| serr_cnt | output | 8 | Serial error counter |
| ovf_cnt | output | 8 | Overflow counter |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions check on every cycle that an errored byte yields no output and advances the error counter, that an event never shares a cycle with a real-time strobe, that every write fits the space reported the cycle before, that the overflow flag stays set once raised and rises only together with a counter step, and that a SysEx opening write carries two bytes. Only the bench scenarios can show the message assembly itself. That covers running-status reuse, one- and two-byte classes, a status byte that cuts a message short, whitelist matches and misses, and the silent velocity-zero drop. The bench checks these against a behavioural model on every clock.

// File: rtl/midi_rx_pkg.sv
package midi_rx_pkg;

  typedef enum logic [2:0] {
    BK_DATA,
    BK_STATUS,
    BK_SX_START,
    BK_SX_END,
    BK_REALTIME
  } byte_kind_t;

  localparam logic [7:0] SX_START_BYTE = 8'hF0;
  localparam logic [7:0] SX_END_BYTE   = 8'hF7;

  // Data bytes needed before a channel message of this class is complete
  function automatic logic [1:0] data_need(input logic [2:0] cls);
    return (cls == 3'd4 || cls == 3'd5) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/midi_rx_classify.sv
module midi_rx_classify
  import midi_rx_pkg::*;
#(
  parameter int N_IDS = 3,
  parameter logic [N_IDS*8-1:0] MFR_IDS = {8'h7E, 8'h41, 8'h50}
) (
  input  logic [7:0]  rx_byte,
  output byte_kind_t  kind,
  output logic        id_hit
);

  logic [N_IDS-1:0] hits;

  for (genvar i = 0; i < N_IDS; i++) begin : g_id
    assign hits[i] = (rx_byte == MFR_IDS[i*8 +: 8]);
  end

  assign id_hit = |hits;

  always_comb begin
    if (!rx_byte[7])                  kind = BK_DATA;
    else if (rx_byte > SX_END_BYTE)   kind = BK_REALTIME;
    else if (rx_byte == SX_START_BYTE) kind = BK_SX_START;
    else if (rx_byte == SX_END_BYTE)  kind = BK_SX_END;
    else                              kind = BK_STATUS;
  end

endmodule

// File: rtl/midi_err_counter.sv
module midi_err_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/midi_rx_parser.sv
module midi_rx_parser
  import midi_rx_pkg::*;
#(
  parameter int FREE_W = 8,
  parameter int CNT_W  = 8,
  parameter int N_IDS  = 3,
  parameter logic [N_IDS*8-1:0] MFR_IDS = {8'h7E, 8'h41, 8'h50}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_err_frame,
  input  logic              rx_err_parity,
  input  logic              rx_err_overrun,
  input  logic [FREE_W-1:0] buf_free,
  output logic              ev_wr,
  output logic [1:0]        ev_len,
  output logic [23:0]       ev_data,
  output logic              rt_valid,
  output logic [7:0]        rt_byte,
  output logic [CNT_W-1:0]  serr_cnt,
  output logic [CNT_W-1:0]  ovf_cnt,
  output logic              ovf_flag
);

  localparam logic [FREE_W-1:0] CHAN_ROOM = FREE_W'(3);

  byte_kind_t kind;
  logic       id_hit;
  logic       any_err, good;

  // parser state
  logic [7:0] run_st, n_run_st;
  logic       dcnt, n_dcnt;
  logic [7:0] d1, n_d1;
  logic       sx_prog, n_sx_prog;
  logic       sx_wait, n_sx_wait;
  logic       sx_capt, n_sx_capt;

  // write request
  logic        want, is_chan, room, wr_req, ovf_hit, silent;
  logic [1:0]  want_len;
  logic [23:0] want_data;
  logic [2:0]  cls;
  logic [1:0]  need;

  midi_rx_classify #(.N_IDS(N_IDS), .MFR_IDS(MFR_IDS)) u_cls (
    .rx_byte (rx_byte),
    .kind    (kind),
    .id_hit  (id_hit)
  );

  assign any_err = rx_err_frame | rx_err_parity | rx_err_overrun;
  assign good    = rx_valid & ~any_err;
  assign cls     = run_st[6:4];
  assign need    = data_need(cls);

  always_comb begin
    n_run_st  = run_st;
    n_dcnt    = dcnt;
    n_d1      = d1;
    n_sx_prog = sx_prog;
    n_sx_wait = sx_wait;
    n_sx_capt = sx_capt;
    want      = 1'b0;
    is_chan   = 1'b0;
    want_len  = 2'd0;
    want_data = '0;
    silent    = 1'b0;
    if (good) begin
      case (kind)
        BK_SX_START: begin
          n_run_st  = rx_byte;
          n_dcnt    = 1'b0;
          n_sx_prog = 1'b1;
          n_sx_wait = 1'b1;
          n_sx_capt = 1'b0;
        end
        BK_SX_END: begin
          n_run_st  = rx_byte;
          n_dcnt    = 1'b0;
          n_sx_prog = 1'b0;
          n_sx_wait = 1'b0;
          n_sx_capt = 1'b0;
          if (sx_capt) begin
            want      = 1'b1;
            want_len  = 2'd1;
            want_data = {16'h0, rx_byte};
          end
        end
        BK_STATUS: begin
          n_run_st  = rx_byte;
          n_dcnt    = 1'b0;
          n_sx_prog = 1'b0;
          n_sx_wait = 1'b0;
          n_sx_capt = 1'b0;
        end
        BK_DATA: begin
          if (!run_st[7]) begin
            // no running status: discard
          end else if (cls == 3'd7) begin
            if (sx_prog && sx_wait) begin
              n_sx_wait = 1'b0;
              if (id_hit) begin
                n_sx_capt = 1'b1;
                want      = 1'b1;
                want_len  = 2'd2;
                want_data = {8'h0, rx_byte, SX_START_BYTE};
              end
            end else if (sx_capt) begin
              want      = 1'b1;
              want_len  = 2'd1;
              want_data = {16'h0, rx_byte};
            end
          end else if (!dcnt && need == 2'd2) begin
            n_d1   = rx_byte;
            n_dcnt = 1'b1;
          end else begin
            n_dcnt    = 1'b0;
            want      = 1'b1;
            is_chan   = 1'b1;
            want_len  = need + 2'd1;
            want_data = (need == 2'd1) ? {8'h0, rx_byte, run_st}
                                       : {rx_byte, d1, run_st};
            silent    = (cls == 3'd1) && (need == 2'd2) && (rx_byte == 8'h00);
          end
        end
        default: ;
      endcase
    end
  end

  assign room    = is_chan ? (buf_free >= CHAN_ROOM)
                           : (buf_free >= {{(FREE_W-2){1'b0}}, want_len});
  assign wr_req  = want & room;
  assign ovf_hit = want & ~room & ~silent;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_st   <= '0;
      dcnt     <= 1'b0;
      d1       <= '0;
      sx_prog  <= 1'b0;
      sx_wait  <= 1'b0;
      sx_capt  <= 1'b0;
      ev_wr    <= 1'b0;
      ev_len   <= '0;
      ev_data  <= '0;
      rt_valid <= 1'b0;
      rt_byte  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      run_st   <= n_run_st;
      dcnt     <= n_dcnt;
      d1       <= n_d1;
      sx_prog  <= n_sx_prog;
      sx_wait  <= n_sx_wait;
      sx_capt  <= n_sx_capt;
      ev_wr    <= wr_req;
      rt_valid <= good && (kind == BK_REALTIME);
      if (wr_req) begin
        ev_len  <= want_len;
        ev_data <= want_data;
      end
      if (good && kind == BK_REALTIME) rt_byte <= rx_byte;
      if (ovf_hit) ovf_flag <= 1'b1;
    end
  end

  midi_err_counter #(.W(CNT_W)) u_serr (
    .clk (clk), .rst (rst), .inc (rx_valid & any_err), .count (serr_cnt)
  );

  midi_err_counter #(.W(CNT_W)) u_ovf (
    .clk (clk), .rst (rst), .inc (ovf_hit), .count (ovf_cnt)
  );

  AST_ERR_DISCARD: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && any_err) |-> (!ev_wr && !rt_valid)); // R1

  AST_ERR_COUNT: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && any_err) |-> (serr_cnt == $past(serr_cnt) + 1'b1)); // R1

  AST_RT_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    rt_valid |-> !ev_wr); // R2

  AST_WR_FITS: assert property (@(posedge clk) disable iff (rst)
    ev_wr |-> ($past(buf_free) >= {{(FREE_W-2){1'b0}}, ev_len})); // R6

  AST_CHAN_ROOM: assert property (@(posedge clk) disable iff (rst)
    (ev_wr && ev_data[7] && ev_data[7:4] != 4'hF) |-> ($past(buf_free) >= CHAN_ROOM)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(ovf_flag) |-> ovf_flag); // R7

  AST_OVF_RISE_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (ovf_cnt == $past(ovf_cnt) + 1'b1)); // R7

  AST_SX_OPEN_LEN: assert property (@(posedge clk) disable iff (rst)
    (ev_wr && ev_data[7:0] == SX_START_BYTE) |-> (ev_len == 2'd2)); // R9

endmodule

// File: tb/sim_midi_rx_parser.sv
module sim_midi_rx_parser;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        fe = 1'b0, pe = 1'b0, oe = 1'b0;
  logic [7:0]  buf_free = 8'd16;
  logic        ev_wr, rt_valid, ovf_flag;
  logic [1:0]  ev_len;
  logic [23:0] ev_data;
  logic [7:0]  rt_byte, serr_cnt, ovf_cnt;

  int checks = 0;
  int errors = 0;
  string req = "R11";
  bit done = 1'b0;

  always #2 clk = ~clk;

  midi_rx_parser u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_err_frame(fe), .rx_err_parity(pe), .rx_err_overrun(oe),
    .buf_free(buf_free), .ev_wr(ev_wr), .ev_len(ev_len), .ev_data(ev_data),
    .rt_valid(rt_valid), .rt_byte(rt_byte), .serr_cnt(serr_cnt),
    .ovf_cnt(ovf_cnt), .ovf_flag(ovf_flag)
  );

  // behavioural reference model
  int m_rs, m_first, m_have;
  bit m_inside, m_await, m_keep;
  bit e_wr, e_rt, e_ovf;
  int e_len;
  logic [23:0] e_data;
  logic [7:0] e_rtb, e_serr, e_ovc;

  task automatic m_emit(input int n, input logic [23:0] d, input bit chan, input bit quiet);
    int space = chan ? 3 : n;
    if (int'(buf_free) >= space) begin
      e_wr = 1; e_len = n; e_data = d;
    end else if (!quiet) begin
      e_ovf = 1; e_ovc = e_ovc + 8'd1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_rs = 0; m_first = 0; m_have = 0; m_inside = 0; m_await = 0; m_keep = 0;
      e_wr = 0; e_rt = 0; e_ovf = 0; e_len = 0; e_data = 0;
      e_rtb = 0; e_serr = 0; e_ovc = 0;
    end else begin
      e_wr = 0; e_rt = 0;
      if (rx_valid) begin
        if (fe || pe || oe) e_serr = e_serr + 8'd1;
        else if (rx_byte >= 8'hF8) begin e_rt = 1; e_rtb = rx_byte; end
        else if (rx_byte >= 8'h80) begin
          if (rx_byte == 8'hF7 && m_keep) m_emit(1, 24'hF7, 0, 0);
          m_rs = rx_byte; m_have = 0;
          m_inside = (rx_byte == 8'hF0); m_await = m_inside; m_keep = 0;
        end else if (m_rs == 0 || (m_rs >= 8'hF0 && !m_inside)) begin
          // ignored
        end else if (m_rs == 8'hF0) begin
          if (m_await) begin
            m_await = 0;
            if (rx_byte == 8'h50 || rx_byte == 8'h41 || rx_byte == 8'h7E) begin
              m_keep = 1; m_emit(2, {8'h00, rx_byte, 8'hF0}, 0, 0);
            end
          end else if (m_keep) m_emit(1, {16'h0, rx_byte}, 0, 0);
        end else if (m_rs >= 8'hC0 && m_rs < 8'hE0) begin
          m_emit(2, {8'h00, rx_byte, 8'(m_rs)}, 1, 0);
        end else if (m_have == 0) begin
          m_first = rx_byte; m_have = 1;
        end else begin
          m_have = 0;
          m_emit(3, {rx_byte, 8'(m_first), 8'(m_rs)}, 1,
                 (m_rs >= 8'h90 && m_rs < 8'hA0 && rx_byte == 0));
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%s] %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(ev_wr == e_wr, "ev_wr", 32'(ev_wr), 32'(e_wr));
      if (e_wr) begin
        chk(ev_len == 2'(e_len), "ev_len", 32'(ev_len), 32'(e_len));
        chk(ev_data == e_data, "ev_data", 32'(ev_data), 32'(e_data));
      end
      chk(rt_valid == e_rt, "rt_valid", 32'(rt_valid), 32'(e_rt));
      if (e_rt) chk(rt_byte == e_rtb, "rt_byte", 32'(rt_byte), 32'(e_rtb));
      chk(serr_cnt == e_serr, "serr_cnt", 32'(serr_cnt), 32'(e_serr));
      chk(ovf_cnt == e_ovc, "ovf_cnt", 32'(ovf_cnt), 32'(e_ovc));
      chk(ovf_flag == e_ovf, "ovf_flag", 32'(ovf_flag), 32'(e_ovf));
    end
  end

  task automatic send(input logic [7:0] b, input int err = 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    fe = (err == 1); pe = (err == 2); oe = (err == 3);
    @(negedge clk);
    rx_valid = 1'b0; fe = 0; pe = 0; oe = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL [watchdog] run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    req = "R11";
    chk(ev_wr == 0 && rt_valid == 0 && serr_cnt == 0 && ovf_cnt == 0 && ovf_flag == 0,
        "reset state", {ev_wr, rt_valid, ovf_flag, serr_cnt, ovf_cnt}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    req = "R4";  send(8'h3C); send(8'h40);
    req = "R6";  send(8'h90); send(8'h3C); send(8'h64);
    req = "R3";  send(8'h40); send(8'h7F); send(8'h41); send(8'h00);
    req = "R5";  send(8'hC5); send(8'h10); send(8'h11);
                 send(8'hD3); send(8'h7F);
                 send(8'hB0); send(8'h07); send(8'h64);
                 send(8'hE2); send(8'h00); send(8'h40);
    req = "R2";  send(8'h90); send(8'h3C); send(8'hF8); send(8'h50); send(8'hFE); send(8'hFF);
    req = "R1";  send(8'h80); send(8'h30, 1); send(8'h30); send(8'h70, 2); send(8'h20, 3); send(8'h21);
    req = "R3";  send(8'h90); send(8'h3C); send(8'h80); send(8'h40); send(8'h00);
    req = "R4";  send(8'hF2); send(8'h10); send(8'h20); send(8'hF7); send(8'h05);
    req = "R9";  send(8'hF0); send(8'h41); send(8'h10); send(8'h20);
    req = "R10"; send(8'hF7);
    req = "R9";  send(8'hF0); send(8'h43); send(8'h11); send(8'h12); send(8'hF7);
                 send(8'hF0); send(8'h7E); send(8'h01); send(8'hF8); send(8'h02); send(8'hF7);
                 send(8'hF0); send(8'h50); send(8'h33);
    req = "R10"; send(8'h90); send(8'h44); send(8'h45);
    req = "R7";  buf_free = 8'd2;
                 send(8'h90); send(8'h3C); send(8'h64);
                 send(8'hC0); send(8'h05);
    req = "R8";  send(8'h90); send(8'h3C); send(8'h00);
                 send(8'h3D); send(8'h00);
    req = "R7";  send(8'h80); send(8'h3C); send(8'h00);
                 buf_free = 8'd1;
                 send(8'hF0); send(8'h41);
                 buf_free = 8'd2;
                 send(8'hF0); send(8'h41); send(8'h22);
                 buf_free = 8'd0;
                 send(8'h23); send(8'hF7);
    req = "R6";  buf_free = 8'd3;
                 send(8'h92); send(8'h10); send(8'h20);
    req = "R1";  for (int i = 0; i < 260; i++) send(8'h55, (i % 3) + 1);
    req = "R2";  send(8'hFA); send(8'hFC);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule